// File: doc/BRIEF.md
# Strobe-Captured Framed Word Serializer

This block takes a 12-bit parallel word, latches it on the rising edge of a strobe that runs in its own clock domain, and sends it out as a continuous stream of 14-slot serial frames timed by a fast bit clock. The bit clock runs at fourteen times the frame (reference) rate and stands in for the multiplied reference clock of a PLL. A lock input gates whether captured data may be sent. Each frame carries the twelve data bits, least significant first, followed by two fixed boundary bits. A forwarded serial clock goes out with the data. That clock skips its pulse in the last slot of every frame, so a receiver can find the word boundary from the clock alone.

The strobe may run at the frame rate or slower, but never faster. A word crosses into the bit-clock domain through a toggle flag and a two-stage synchronizer. Any frame that starts with no new word waiting carries a data value of zero. In this transmit-only configuration the receive path is absent, except that a receive clock input is passed straight through to a clock output.

Top module: `strobe_serializer`

## Requirements
- R1: On each rising edge of `strobe_i` the 12-bit `data_i` is captured. That captured value is the one later sent, with no other word mixed in.
- R2: Frames are 14 bit-clock slots long and follow each other with no gap. `ser_data_o` changes on the rising edge of `clk_bit_i`. Slot k (k=1..12) carries data bit k-1, slot 13 carries 1 and slot 14 carries 0.
- R3: A frame phase counter steps 0..13 and wraps. The next frame is loaded on the rising edge where the phase wraps from 13 to 0.
- R4: A strobe edge that falls between two bit-clock rising edges makes its word pending on the third following rising edge. The word is loaded at the first wrap edge strictly after that, and it is sent in exactly one frame.
- R5: If no word is pending at a wrap edge, the frame carries data value zero, with its boundary bits intact.
- R6: If `lock_i` is low at a wrap edge, the frame carries data value zero and any pending word is discarded.
- R7: A word that becomes pending while another is still pending and not being loaded replaces the older word. It also sets `ovr_err_o`, which stays set until reset.
- R8: `ser_clk_o` follows `clk_bit_i`, except that it stays low for the high half of slot 14 of every frame.
- R9: `clk_pass_o` follows `rx_clk_i` combinationally at all times.
- R10: While `rst_ni` is low, `ser_data_o` and `ovr_err_o` are 0 and the phase and pending state are cleared. After release, frame slots carry 0 until the first wrap, which comes at the 14th bit-clock rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit_i | input | 1 | Bit clock, 14 times the frame rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lock_i | input | 1 | Clock lock indication; high allows data to be sent |
| strobe_i | input | 1 | Word capture strobe, rising edge active |
| data_i | input | 12 | Parallel data word |
| rx_clk_i | input | 1 | Receive clock input for pass-through |
| ser_data_o | output | 1 | Serial data, one bit per bit-clock slot |
| ser_clk_o | output | 1 | Forwarded bit clock with the slot-14 pulse removed |
| clk_pass_o | output | 1 | Copy of `rx_clk_i` |
| ovr_err_o | output | 1 | Sticky overrun flag |

## Verification
The bench drives strobes at the frame rate with varied phase offsets against the frame boundary. This catches a design that sends a word one frame early or late, or that sends it twice when the crossing latency is off by a cycle. Strobe gaps longer than a frame expose a design that repeats stale data instead of sending zero. Words sent before lock expose a design that leaks them or keeps them pending for later. Closely spaced strobes check that the overrun flag rises and stays set, and that only the newer word is sent. Every slot of `ser_clk_o` is sampled, so a gap placed in the wrong slot shows up.

// File: rtl/strobe_serializer_pkg.sv
package strobe_serializer_pkg;
  localparam int DATA_W      = 12;
  localparam int SYNC_STAGES = 2;
  localparam int FRAME_W     = DATA_W + 2;
  // boundary bits as they sit at the top of the frame register: {slot14, slot13}
  localparam logic [1:0] FRAME_TAIL = 2'b01;
endpackage

// File: rtl/ss_capture.sv
module ss_capture #(
  parameter int DATA_W = strobe_serializer_pkg::DATA_W
) (
  input  logic              strobe_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] hold_o,
  output logic              tog_o
);
  always_ff @(posedge strobe_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_o <= '0;
      tog_o  <= 1'b0;
    end else begin
      hold_o <= data_i;
      tog_o  <= ~tog_o;
    end
  end
endmodule

// File: rtl/ss_sync.sv
module ss_sync #(
  parameter int SYNC_STAGES = strobe_serializer_pkg::SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tog_i,
  output logic new_word_o
);
  localparam int CHAIN = SYNC_STAGES + 1;
  logic [CHAIN-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < CHAIN; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[g] <= 1'b0;
          else         chain_q[g] <= tog_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[g] <= 1'b0;
          else         chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  // edge of the synchronized toggle marks exactly one new word
  assign new_word_o = chain_q[SYNC_STAGES-1] ^ chain_q[SYNC_STAGES];

  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_word_o |=> !new_word_o);
endmodule

// File: rtl/ss_pending.sv
module ss_pending #(
  parameter int DATA_W = strobe_serializer_pkg::DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              new_word_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              load_i,
  output logic              pend_o,
  output logic [DATA_W-1:0] pend_data_o,
  output logic              err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o      <= 1'b0;
      pend_data_o <= '0;
      err_o       <= 1'b0;
    end else begin
      if (new_word_i) begin
        pend_o      <= 1'b1;
        pend_data_o <= word_i;
      end else if (load_i) begin
        pend_o <= 1'b0;
      end
      if (new_word_i && pend_o && !load_i) err_o <= 1'b1;
    end
  end

  a_r7_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  a_r7_overrun_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (new_word_i && pend_o && !load_i) |=> err_o);
  a_r4_word_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_word_i |=> pend_o);
endmodule

// File: rtl/ss_framer.sv
module ss_framer #(
  parameter int DATA_W = strobe_serializer_pkg::DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lock_i,
  input  logic              pend_i,
  input  logic [DATA_W-1:0] pend_data_i,
  output logic              load_o,
  output logic              ser_data_o,
  output logic              ser_clk_o
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int PHASE_W = $clog2(FRAME_W);
  localparam logic [PHASE_W-1:0] LAST = PHASE_W'(FRAME_W - 1);
  localparam logic [PHASE_W-1:0] PRE  = PHASE_W'(FRAME_W - 2);

  logic [PHASE_W-1:0] phase_q;
  logic [FRAME_W-1:0] shift_q;
  logic               gap_q;
  logic [DATA_W-1:0]  payload;

  assign load_o  = (phase_q == LAST);
  assign payload = (pend_i && lock_i) ? pend_data_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else         phase_q <= load_o ? '0 : phase_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     shift_q <= '0;
    else if (load_o) shift_q <= {strobe_serializer_pkg::FRAME_TAIL, payload};
    else             shift_q <= {1'b0, shift_q[FRAME_W-1:1]};
  end

  // enable changes while the clock is low, covering the high half of slot 14
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gap_q <= 1'b0;
    else         gap_q <= (phase_q == PRE);
  end

  assign ser_data_o = shift_q[0];
  assign ser_clk_o  = clk_i & ~gap_q;

  a_r3_phase_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q <= LAST);
  a_r2_last_slot_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == LAST) |-> !ser_data_o);
  a_r6_unlocked_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && !lock_i) |=> (shift_q[DATA_W-1:0] == '0));
  a_r8_gap_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PRE) |-> gap_q);
endmodule

// File: rtl/strobe_serializer.sv
module strobe_serializer #(
  parameter int DATA_W      = strobe_serializer_pkg::DATA_W,
  parameter int SYNC_STAGES = strobe_serializer_pkg::SYNC_STAGES
) (
  input  logic              clk_bit_i,
  input  logic              rst_ni,
  input  logic              lock_i,
  input  logic              strobe_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              rx_clk_i,
  output logic              ser_data_o,
  output logic              ser_clk_o,
  output logic              clk_pass_o,
  output logic              ovr_err_o
);
  logic [DATA_W-1:0] hold;
  logic              tog;
  logic              new_word;
  logic              load;
  logic              pend;
  logic [DATA_W-1:0] pend_data;

  ss_capture #(.DATA_W(DATA_W)) u_capture (
    .strobe_i(strobe_i), .rst_ni(rst_ni), .data_i(data_i),
    .hold_o(hold), .tog_o(tog)
  );

  ss_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_bit_i), .rst_ni(rst_ni), .tog_i(tog), .new_word_o(new_word)
  );

  ss_pending #(.DATA_W(DATA_W)) u_pending (
    .clk_i(clk_bit_i), .rst_ni(rst_ni), .new_word_i(new_word), .word_i(hold),
    .load_i(load), .pend_o(pend), .pend_data_o(pend_data), .err_o(ovr_err_o)
  );

  ss_framer #(.DATA_W(DATA_W)) u_framer (
    .clk_i(clk_bit_i), .rst_ni(rst_ni), .lock_i(lock_i), .pend_i(pend),
    .pend_data_i(pend_data), .load_o(load), .ser_data_o(ser_data_o),
    .ser_clk_o(ser_clk_o)
  );

  assign clk_pass_o = rx_clk_i;

  a_r9_pass_through: assert property (@(posedge clk_bit_i) disable iff (!rst_ni)
    clk_pass_o == rx_clk_i);
endmodule

// File: tb/strobe_serializer_tb.sv
module strobe_serializer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lock = 1'b0;
  logic        strobe = 1'b0;
  logic [11:0] data = '0;
  logic        rx_clk = 1'b0;
  logic        ser_data, ser_clk, clk_pass, ovr_err;

  int tests = 0;
  int fails = 0;

  // reference model state
  int          m_phase;
  logic        m_pend;
  logic [11:0] m_pdata;
  logic        m_err;
  logic        exp_q[$];
  int          in_age[$];
  logic [11:0] in_data[$];
  logic        m_load, m_arrive, m_exp;
  logic [11:0] m_adata;

  always #2 clk = ~clk;

  strobe_serializer u_dut (
    .clk_bit_i(clk), .rst_ni(rst_n), .lock_i(lock), .strobe_i(strobe),
    .data_i(data), .rx_clk_i(rx_clk), .ser_data_o(ser_data),
    .ser_clk_o(ser_clk), .clk_pass_o(clk_pass), .ovr_err_o(ovr_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  task automatic model_reset();
    m_phase = 0; m_pend = 1'b0; m_pdata = '0; m_err = 1'b0;
    exp_q.delete(); in_age.delete(); in_data.delete();
    for (int i = 0; i < 13; i++) exp_q.push_back(1'b0);
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      m_load   = (m_phase == 13);
      m_arrive = 1'b0;
      m_adata  = '0;
      foreach (in_age[i]) in_age[i] = in_age[i] + 1;
      if (in_age.size() > 0 && in_age[0] == 3) begin
        m_arrive = 1'b1;
        m_adata  = in_data.pop_front();
        void'(in_age.pop_front());
      end
      if (m_load) begin
        for (int i = 0; i < 12; i++) exp_q.push_back((m_pend && lock) ? m_pdata[i] : 1'b0);
        exp_q.push_back(1'b1);
        exp_q.push_back(1'b0);
      end
      if (m_arrive && m_pend && !m_load) m_err = 1'b1;
      if (m_arrive) begin m_pend = 1'b1; m_pdata = m_adata; end
      else if (m_load) m_pend = 1'b0;
      m_phase = m_load ? 0 : m_phase + 1;
      m_exp = (exp_q.size() > 0) ? exp_q.pop_front() : 1'bx;
      #1;
      // R1 R2 R4 R5 R6: serial stream against model
      check(ser_data === m_exp, "R2/R4/R5/R6 ser_data", int'(ser_data), int'(m_exp));
      check(ovr_err === m_err, "R7 ovr_err", int'(ovr_err), int'(m_err));
      check(ser_clk === (m_phase != 13), "R8 ser_clk", int'(ser_clk), int'(m_phase != 13));
    end
  end

  task automatic send_word(input logic [11:0] d);
    @(negedge clk);
    data = d;
    #1 strobe = 1'b1;
    in_data.push_back(d);
    in_age.push_back(0);
    @(negedge clk);
    strobe = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    wait_cyc(4);
    check(ser_data === 1'b0, "R10 ser_data in reset", int'(ser_data), 0);
    check(ovr_err === 1'b0, "R10 ovr_err in reset", int'(ovr_err), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    #600000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();
    // R9 pass-through
    rx_clk = 1'b1; #0.5;
    check(clk_pass === 1'b1, "R9 clk_pass high", int'(clk_pass), 1);
    rx_clk = 1'b0; #0.5;
    check(clk_pass === 1'b0, "R9 clk_pass low", int'(clk_pass), 0);

    // R6: words before lock are dropped
    for (int i = 0; i < 3; i++) begin send_word(12'hA50 + 12'(i)); wait_cyc(18); end
    wait_cyc(30);

    // R1/R4: lock, words at frame rate with shifting offsets
    @(negedge clk); lock = 1'b1;
    for (int off = 0; off < 5; off++) begin
      wait_cyc(off);
      for (int i = 0; i < 6; i++) begin send_word(12'($urandom)); wait_cyc(12); end
      wait_cyc(20);
    end

    // R5: slower strobe leaves zero frames
    for (int i = 0; i < 10; i++) begin send_word(12'($urandom)); wait_cyc(15 + (i * 3) % 16); end
    send_word(12'hFFF); wait_cyc(30);
    send_word(12'h001); wait_cyc(30);

    // R6: lock dropped with a word pending
    send_word(12'h5A5);
    @(negedge clk); lock = 1'b0;
    wait_cyc(40);
    @(negedge clk); lock = 1'b1;
    wait_cyc(20);

    // R7: overrun
    check(ovr_err === 1'b0, "R7 no overrun yet", int'(ovr_err), 0);
    for (int i = 0; i < 4; i++) begin
      send_word(12'h3C0 + 12'(i)); wait_cyc(3);
      send_word(12'hC30 + 12'(i)); wait_cyc(25);
    end
    check(ovr_err === 1'b1, "R7 overrun flagged", int'(ovr_err), 1);
    wait_cyc(30);
    check(ovr_err === 1'b1, "R7 flag sticky", int'(ovr_err), 1);

    // R10: reset clears flag, restart
    do_reset();
    wait_cyc(2);
    check(ovr_err === 1'b0, "R10 flag cleared", int'(ovr_err), 0);
    for (int i = 0; i < 8; i++) begin send_word(12'($urandom)); wait_cyc(14 + i); end
    wait_cyc(50);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule